// File: doc/BRIEF.md
# Indirect-Access SPI Byte Engine

A host-controlled SPI master that a processor drives one byte at a time through a three-port indirect register window. The host first writes a bank byte and an offset byte. Together they select a 16-bit internal address, with the bank in bits 15:8 and the offset in bits 7:0. A third port then reads or writes the byte at that address. Three internal registers sit behind the window: a receive data register, a command register and a configuration register.

Writing the command register shifts that byte out on MOSI in SPI mode 0, most significant bit first. The byte clocked in on MISO during the same shift is then available in the data register. To read a flash byte, the host writes 0x00 as a dummy command, waits for the busy flag to clear, and reads the data register.

Chip select is not framed per byte. A configuration bit holds it low, so software can build a multi-byte flash transaction from single-byte shifts. That bit only takes effect when a write-enable bit is set in the same configuration write. The serial clock is the system clock divided by the even parameter `DIV`.

Top module: `ispi_engine`

## Requirements
- R1: Host port code 1 writes and reads the bank byte and port code 2 the offset byte. Port code 3 reads or writes the register at internal address {bank, offset}. Port code 0 reads 0 and ignores writes. An unmapped internal address reads 0 and ignores writes.
- R2: After reset, spi_cs_n is 1, spi_sclk is 0, the configuration register (0xFEAD) reads 0x00, and the bank and offset read 0.
- R3: A configuration write with bit 3 (0x08, write enable) set copies bit 4 (0x10) to the chip-select hold. spi_cs_n is then the inverse of that bit from the cycle after the write. A configuration write with bit 3 clear leaves spi_cs_n unchanged.
- R4: Configuration bits 0 and 3 read back as last written, and bit 4 reads the chip-select hold. Bit 1 reads 1 while a shift is in progress only if bit 0 (busy-check enable) is set; otherwise it reads 0. Bits 7:5 and 2 read 0.
- R5: A write to the command register (0xFEAC) while idle shifts its byte out on spi_mosi MSB first in SPI mode 0. spi_sclk idles low, makes exactly 8 rising edges, and has a period of DIV system clocks. spi_mosi is stable while spi_sclk is high.
- R6: spi_miso is sampled on each rising spi_sclk edge, MSB first. The byte is placed in the data register (0xFEAB) when the shift ends. Busy stays high for exactly 8*DIV cycles from the cycle after the command write.
- R7: A command write that arrives while busy is ignored. The shift in progress completes with its original byte, and the command register keeps that byte.
- R8: spi_cs_n does not change at shift boundaries. It stays low across consecutive shifts while the hold is set.
- R9: Host writes to the data register are ignored.
- R10: Reading the command register returns the byte of the last accepted command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_port | input | 2 | Host port select: 1 bank, 2 offset, 3 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the selected port, combinational |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low, software held |
| spi_mosi | output | 1 | Serial data out, MSB first |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench attacks the exact busy length. A shifter that stops one half-period early or late would clear busy on the wrong cycle, and a dummy-read loop would then pick up a stale or half-shifted byte. It writes configuration values whose chip-select bit differs from the hold but whose write-enable bit is clear. A design that ignored the enable would release chip select in the middle of a flash transaction. It also sends a second command while a shift is in flight. A design that accepted it would restart the bit counter, and the slave would then see more than 8 clocks or a corrupted byte. Finally, it confirms that the data register does not accept host writes and that chip select never rises between back-to-back bytes.

// File: rtl/ispi_pkg.sv
`timescale 1ns/1ps
package ispi_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  // host port codes
  localparam logic [1:0] PORT_BANK = 2'd1;
  localparam logic [1:0] PORT_OFS  = 2'd2;
  localparam logic [1:0] PORT_DATA = 2'd3;

  // internal addresses
  localparam logic [ADDR_W-1:0] ADDR_RXDATA = 16'hFEAB;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 16'hFEAC;
  localparam logic [ADDR_W-1:0] ADDR_CFG    = 16'hFEAD;

  // configuration bit positions
  localparam int CFG_HOLD_BIT = 4;
  localparam int CFG_WEN_BIT  = 3;
  localparam int CFG_BUSY_BIT = 1;
  localparam int CFG_CHK_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RX   = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_CFG  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ispi_rst_sync.sv
`timescale 1ns/1ps
module ispi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ispi_window.sv
`timescale 1ns/1ps
module ispi_window
  import ispi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_port,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] cfg_byte,
  output logic              cmd_wr,
  output logic              cfg_wr,
  output logic [BYTE_W-1:0] host_rdata
);
  logic [BYTE_W-1:0] bank_q, bank_d;
  logic [BYTE_W-1:0] ofs_q, ofs_d;
  logic              bank_en, ofs_en;
  logic [ADDR_W-1:0] int_addr;
  reg_sel_e          sel;
  logic              data_wr;
  logic [BYTE_W-1:0] reg_rdata;

  assign int_addr = {bank_q, ofs_q};

  // address decode
  always_comb begin
    unique case (int_addr)
      ADDR_RXDATA: sel = SEL_RX;
      ADDR_CMD:    sel = SEL_CMD;
      ADDR_CFG:    sel = SEL_CFG;
      default:     sel = SEL_NONE;
    endcase
  end

  // next state for the window registers
  always_comb begin
    bank_en = host_wr && (host_port == PORT_BANK);
    ofs_en  = host_wr && (host_port == PORT_OFS);
    bank_d  = host_wdata;
    ofs_d   = host_wdata;
    data_wr = host_wr && (host_port == PORT_DATA);
    cmd_wr  = data_wr && (sel == SEL_CMD);
    cfg_wr  = data_wr && (sel == SEL_CFG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (bank_en) bank_q <= bank_d;
      if (ofs_en)  ofs_q  <= ofs_d;
    end
  end

  // read path
  always_comb begin
    unique case (sel)
      SEL_RX:  reg_rdata = rx_byte;
      SEL_CMD: reg_rdata = cmd_byte;
      SEL_CFG: reg_rdata = cfg_byte;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    unique case (host_port)
      PORT_BANK: host_rdata = bank_q;
      PORT_OFS:  host_rdata = ofs_q;
      PORT_DATA: host_rdata = reg_rdata;
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ispi_cfg.sv
`timescale 1ns/1ps
module ispi_cfg
  import ispi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              wr_hold,
  input  logic              wr_wen,
  input  logic              wr_chk,
  input  logic              busy,
  output logic              cs_n,
  output logic [BYTE_W-1:0] cfg_byte
);
  logic csn_q, csn_d, csn_en;
  logic wen_q, wen_d;
  logic chk_q, chk_d;
  logic flag_en;

  always_comb begin
    flag_en = cfg_wr;
    wen_d   = wr_wen;
    chk_d   = wr_chk;
    csn_en  = cfg_wr && wr_wen;
    csn_d   = ~wr_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 1'b1;
      wen_q <= 1'b0;
      chk_q <= 1'b0;
    end else begin
      if (csn_en) csn_q <= csn_d;
      if (flag_en) begin
        wen_q <= wen_d;
        chk_q <= chk_d;
      end
    end
  end

  always_comb begin
    cfg_byte               = '0;
    cfg_byte[CFG_HOLD_BIT] = ~csn_q;
    cfg_byte[CFG_WEN_BIT]  = wen_q;
    cfg_byte[CFG_BUSY_BIT] = busy & chk_q;
    cfg_byte[CFG_CHK_BIT]  = chk_q;
  end

  assign cs_n = csn_q;
endmodule

// File: rtl/ispi_shifter.sv
`timescale 1ns/1ps
module ispi_shifter
  import ispi_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] cmd_byte
);
  localparam int HALF  = DIV / 2;
  localparam int CW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW   = $clog2(BYTE_W);
  localparam logic [CW-1:0]  HALF_LAST = CW'(HALF - 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(BYTE_W - 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BCW-1:0]    fall_q, fall_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic [BYTE_W-1:0] in_q, in_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic              rx_en, cmd_en, accept;

  assign accept = start && !busy_q;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    fall_d = fall_q;
    out_d  = out_q;
    in_d   = in_q;
    rx_d   = in_q;
    rx_en  = 1'b0;
    cmd_d  = tx_byte;
    cmd_en = accept;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        cnt_d  = '0;
        fall_d = '0;
        out_d  = tx_byte;
      end
    end else if (cnt_q == HALF_LAST) begin
      cnt_d = '0;
      if (!sclk_q) begin
        // rising edge: sample the slave
        sclk_d = 1'b1;
        in_d   = {in_q[BYTE_W-2:0], miso};
      end else begin
        // falling edge: advance or finish
        sclk_d = 1'b0;
        fall_d = fall_q + 1'b1;
        if (fall_q == BIT_LAST) begin
          busy_d = 1'b0;
          rx_en  = 1'b1;
        end else begin
          out_d = {out_q[BYTE_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      fall_q <= '0;
      out_q  <= '0;
      in_q   <= '0;
      rx_q   <= '0;
      cmd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      fall_q <= fall_d;
      out_q  <= out_d;
      in_q   <= in_d;
      if (rx_en)  rx_q  <= rx_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign busy     = busy_q;
  assign sclk     = sclk_q;
  assign mosi     = out_q[BYTE_W-1];
  assign rx_byte  = rx_q;
  assign cmd_byte = cmd_q;
endmodule

// File: rtl/ispi_engine.sv
`timescale 1ns/1ps
module ispi_engine
  import ispi_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [1:0] host_port,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic              sys_rst_n;
  logic              cmd_wr, cfg_wr;
  logic              shift_busy;
  logic [BYTE_W-1:0] rx_byte, cmd_byte, cfg_byte;

  ispi_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (sys_rst_n)
  );

  ispi_window u_win (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .host_wr    (host_wr),
    .host_port  (host_port),
    .host_wdata (host_wdata),
    .rx_byte    (rx_byte),
    .cmd_byte   (cmd_byte),
    .cfg_byte   (cfg_byte),
    .cmd_wr     (cmd_wr),
    .cfg_wr     (cfg_wr),
    .host_rdata (host_rdata)
  );

  ispi_cfg u_cfg (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .cfg_wr   (cfg_wr),
    .wr_hold  (host_wdata[CFG_HOLD_BIT]),
    .wr_wen   (host_wdata[CFG_WEN_BIT]),
    .wr_chk   (host_wdata[CFG_CHK_BIT]),
    .busy     (shift_busy),
    .cs_n     (spi_cs_n),
    .cfg_byte (cfg_byte)
  );

  ispi_shifter #(.DIV(DIV)) u_shift (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .start    (cmd_wr),
    .tx_byte  (host_wdata),
    .miso     (spi_miso),
    .busy     (shift_busy),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .rx_byte  (rx_byte),
    .cmd_byte (cmd_byte)
  );
endmodule

// File: rtl/ispi_engine_chk.sv
`timescale 1ns/1ps
module ispi_engine_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic sys_rst_n,
  input logic cmd_wr,
  input logic cfg_wr,
  input logic wen_bit,
  input logic busy,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi
);
  localparam int HALF  = DIV / 2;
  localparam int SPAN  = 16 * HALF;
  localparam int SCW   = $clog2(SPAN + 1);

  logic [SCW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  busy_cnt <= '0;
    else if (busy)   busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R5: clock idles low between shifts
  a_r5_idle_sclk_low: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !busy |-> !spi_sclk);

  // R5: data out does not move while the clock is high
  a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!sys_rst_n)
    spi_sclk |-> $stable(spi_mosi));

  // R6: busy lasts exactly sixteen half periods
  a_r6_busy_exact: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(busy) |-> (busy_cnt == SCW'(SPAN)));

  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!sys_rst_n)
    busy |-> (busy_cnt < SCW'(SPAN)));

  // R7: a shift only begins from a command write
  a_r7_start_from_cmd: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(busy) |-> $past(cmd_wr));

  // R3 / R8: chip select moves only on an enabled configuration write
  a_r3_cs_needs_wen: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !(cfg_wr && wen_bit) |=> $stable(spi_cs_n));
endmodule

bind ispi_engine ispi_engine_chk #(.DIV(DIV)) u_chk (
  .clk       (clk),
  .sys_rst_n (sys_rst_n),
  .cmd_wr    (cmd_wr),
  .cfg_wr    (cfg_wr),
  .wen_bit   (host_wdata[3]),
  .busy      (shift_busy),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/sim_ispi_engine.sv
`timescale 1ns/1ps
module sim_ispi_engine;
  localparam int DIV = 6;
  localparam int TCK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_port = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int n_cmp = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  ispi_engine #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // slave model: mode 0, MSB first
  logic [7:0] slave_byte = 8'h00;
  logic [7:0] slave_rx = 8'h00;
  logic [2:0] slave_idx = 3'd0;
  int         rise_cnt = 0;
  int         cs_rise_cnt = 0;
  longint     last_rise = 0;
  longint     sclk_period = 0;

  assign spi_miso = slave_byte[3'd7 - slave_idx];

  always @(posedge spi_sclk) begin
    slave_rx <= {slave_rx[6:0], spi_mosi};
    rise_cnt = rise_cnt + 1;
    if (last_rise != 0) sclk_period = $time - last_rise;
    last_rise = $time;
  end
  always @(negedge spi_sclk) slave_idx <= slave_idx + 3'd1;
  always @(posedge spi_cs_n) cs_rise_cnt = cs_rise_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic hw(input logic [1:0] p, input logic [7:0] d);
    host_port = p; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] p, output logic [7:0] d);
    host_port = p;
    #1;
    d = host_rdata;
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [7:0] d);
    hw(2'd1, a[15:8]);
    hw(2'd2, a[7:0]);
    hw(2'd3, d);
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [7:0] d);
    hw(2'd1, a[15:8]);
    hw(2'd2, a[7:0]);
    hr(2'd3, d);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    hr(2'd3, v);
    while (v[1] && n < 2000) begin
      n++;
      @(negedge clk);
      hr(2'd3, v);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R2 cs_n after reset", spi_cs_n, 1);
    check("R2 sclk after reset", spi_sclk, 0);
    hr(2'd1, v); check("R2 bank after reset", v, 8'h00);
    hr(2'd2, v); check("R2 offset after reset", v, 8'h00);
    @(negedge clk);
    reg_rd(16'hFEAD, v); check("R2 config after reset", v, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_window;
    logic [7:0] v;
    hw(2'd1, 8'h12);
    hw(2'd2, 8'h34);
    hr(2'd1, v); check("R1 bank readback", v, 8'h12);
    hr(2'd2, v); check("R1 offset readback", v, 8'h34);
    hr(2'd3, v); check("R1 unmapped reads 0", v, 8'h00);
    @(negedge clk);
    hw(2'd3, 8'h55);
    hr(2'd3, v); check("R1 unmapped write ignored", v, 8'h00);
    @(negedge clk);
    hw(2'd0, 8'hFF);
    hr(2'd1, v); check("R1 port 0 write ignored (bank)", v, 8'h12);
    hr(2'd2, v); check("R1 port 0 write ignored (offset)", v, 8'h34);
    hr(2'd0, v); check("R1 port 0 reads 0", v, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_config;
    logic [7:0] v;
    reg_wr(16'hFEAD, 8'h10);
    check("R3 hold without wen keeps cs high", spi_cs_n, 1);
    hr(2'd3, v); check("R4 readback 0x10 write", v, 8'h00);
    @(negedge clk);
    hw(2'd3, 8'hFF);
    check("R3 0xFF write drives cs low", spi_cs_n, 0);
    hr(2'd3, v); check("R4 unused bits read 0", v, 8'h19);
    @(negedge clk);
    hw(2'd3, 8'h01);
    check("R3 release without wen keeps cs low", spi_cs_n, 0);
    hr(2'd3, v); check("R4 readback 0x01 write", v, 8'h11);
    @(negedge clk);
    hw(2'd3, 8'h09);
    check("R3 release with wen raises cs", spi_cs_n, 1);
    @(negedge clk);
  endtask

  task automatic t_xfer_timed;
    logic [7:0] v;
    int n;
    reg_wr(16'hFEAD, 8'h19);
    slave_byte = 8'hA5;
    rise_cnt = 0; last_rise = 0;
    reg_wr(16'hFEAC, 8'h3C);   // edge T; now at sample after T
    hw(2'd2, 8'hAD);           // sample after T+1
    wait_idle(n);
    check("R6 busy length", n, 8 * DIV - 1);
    check("R5 rising edge count", rise_cnt, 8);
    check("R5 sclk period", 32'(sclk_period), DIV * TCK);
    check("R5 slave saw command byte", slave_rx, 8'h3C);
    check("R5 sclk idle low", spi_sclk, 0);
    @(negedge clk);
    reg_rd(16'hFEAB, v); check("R6 data register holds miso byte", v, 8'hA5);
    @(negedge clk);
    hw(2'd2, 8'hAC);
    hr(2'd3, v); check("R10 command readback", v, 8'h3C);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, output logic [7:0] got);
    int n;
    slave_byte = sl;
    rise_cnt = 0;
    reg_wr(16'hFEAC, tx);
    hw(2'd2, 8'hAD);
    wait_idle(n);
    @(negedge clk);
    reg_rd(16'hFEAB, got);
    @(negedge clk);
  endtask

  task automatic t_multi_byte;
    logic [7:0] v;
    int cs0;
    cs0 = cs_rise_cnt;
    xfer(8'h9F, 8'h00, v);
    check("R5 first byte to slave", slave_rx, 8'h9F);
    check("R8 cs low after first byte", spi_cs_n, 0);
    xfer(8'h00, 8'hC2, v);
    check("R6 dummy read returns slave byte", v, 8'hC2);
    xfer(8'h00, 8'h81, v);
    check("R6 second dummy read", v, 8'h81);
    check("R8 cs low across bytes", spi_cs_n, 0);
    check("R8 no cs rise during transaction", cs_rise_cnt - cs0, 0);
  endtask

  task automatic t_overlap;
    logic [7:0] v;
    int n;
    slave_byte = 8'h5A;
    rise_cnt = 0;
    reg_wr(16'hFEAC, 8'h81);
    repeat (5) @(negedge clk);
    hw(2'd3, 8'h7E);           // while busy
    hw(2'd2, 8'hAD);
    wait_idle(n);
    check("R7 edges unchanged by late command", rise_cnt, 8);
    check("R7 slave saw original byte", slave_rx, 8'h81);
    @(negedge clk);
    reg_rd(16'hFEAC, v); check("R7 command register kept", v, 8'h81);
    @(negedge clk);
    reg_rd(16'hFEAB, v); check("R7 data intact", v, 8'h5A);
    @(negedge clk);
  endtask

  task automatic t_data_ro;
    logic [7:0] v;
    reg_wr(16'hFEAB, 8'hEE);
    hr(2'd3, v); check("R9 data register write ignored", v, 8'h5A);
    check("R9 no shift from data write", spi_sclk, 0);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_window();
    t_config();
    t_xfer_timed();
    t_multi_byte();
    t_overlap();
    t_data_ro();
    finish_run();
  end
endmodule